// File: doc/BRIEF.md
# Buffered Serial Transmit Channel

This block is the transmit half of an asynchronous serial port. A single holding register takes one character from a valid/ready input stream. When the shift engine is free, it moves that character into its own shift register. The engine then drives a frame onto the serial line: a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and a high stop period of 1, 1.5 or 2 bit times. The bit rate comes from a programmable 16-bit divisor. One baud tick occurs every `divisor` clock cycles, and every bit lasts 16 ticks.

Two status outputs report the state of the channel. `hold_empty` shows that the holding register can take a character. `tx_empty` shows that nothing is queued and the last frame has completely left the line. Two pin controls override the line. `force_break` drives the line low and works even while the tick enable is off. `loopback` holds the pin high and sends the frame on a separate internal output meant for a receiver.

The input stream obeys valid/ready rules. A character transfers on a clock edge where both `in_valid` and `in_ready` are high. While `in_ready` is low, the source must keep `in_valid` and `in_data` stable. A second character can therefore wait while the current frame is sent. The frame format is captured when a character enters the shifter, so format changes made during a frame apply to the next frame.

Top module: `serial_tx_channel`

## Requirements
- R1: After reset `txd` and `loop_txd` are high, and `hold_empty`, `in_ready` and `tx_empty` are all high.
- R2: A frame is a low start bit, then the data bits least significant bit first, with the bit count set by `data_len` (0: 5, 1: 6, 2: 7, 3: 8 bits). Every bit lasts 16 baud ticks, and one baud tick occurs every `divisor` clock cycles while `clk_en` is high.
- R3: `par_mode` 1 appends an even-parity bit and `par_mode` 2 appends an odd-parity bit after the data bits. The parity is computed over the data bits that are sent. `par_mode` 0 and 3 send no parity bit.
- R4: The stop period is high and lasts 16 ticks when `stop_long` is 0. When `stop_long` is 1 it lasts 24 ticks with 5 data bits and 32 ticks with 6, 7 or 8 data bits.
- R5: A `divisor` value of 0 gives 65536 clock cycles between baud ticks.
- R6: An accepted character makes `hold_empty`/`in_ready` low from the next cycle. They return high in the cycle after the character is copied into the shifter. A character offered while `in_ready` is low is not taken and is not lost.
- R7: `tx_empty` is high only when the holding register is empty and the engine is idle. It rises one cycle before the final stop period would end on the pin.
- R8: A frame starts on the first baud tick after the copy. A character waiting at the end of a stop period is copied on that period's last tick, and its start bit follows with no idle gap. The starts of consecutive frames are therefore exactly one frame length apart.
- R9: While `loopback` is 1, `txd` stays high and `loop_txd` carries the frame. While `loopback` is 0, `loop_txd` stays high.
- R10: `force_break` drives `txd` low one cycle after it is raised, whatever the values of `clk_en` and `loopback`. `txd` returns to the line value one cycle after `force_break` is released.
- R11: `data_len`, `par_mode` and `stop_long` are captured when a character enters the shifter. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Enables the baud tick generator |
| divisor | input | 16 | Clock cycles per baud tick (0 means 65536) |
| data_len | input | 2 | Data bit count code, 5 + value |
| par_mode | input | 2 | 1 even, 2 odd, 0 or 3 none |
| stop_long | input | 1 | Selects the long stop period |
| force_break | input | 1 | Forces the serial pin low |
| loopback | input | 1 | Holds the pin high and routes the frame to `loop_txd` |
| in_valid | input | 1 | Character offered on `in_data` |
| in_data | input | 8 | Character to send |
| in_ready | output | 1 | Holding register can take a character |
| hold_empty | output | 1 | Holding register is empty |
| tx_empty | output | 1 | Holding register and shifter are both empty |
| txd | output | 1 | Serial output pin, registered |
| loop_txd | output | 1 | Internal serial stream for loopback, registered |

## Verification
The pin outputs are registered, so a start bit shows on `txd` one cycle after the engine enters its start phase. The bench takes the first falling edge it sees at a falling clock edge as the frame reference. It then samples each bit at its centre, (16·i + 8)·divisor cycles after that reference. A queued character raises `hold_empty` at reference + N·divisor − 1, and the next start edge appears at exactly reference + N·divisor, where N is the frame length in ticks. `tx_empty` rises at the same offset when nothing is queued. The bench checks the flag one cycle before and at each of these points. Break takes effect one cycle after it changes. The divisor-zero case is checked against a window of about 65536 cycles between the write and the start edge. A sweep covers every combination of data length, parity and stop setting with two characters sent back to back.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_WAIT,
    TX_START,
    TX_DATA,
    TX_PAR,
    TX_STOP
  } tx_phase_e;

  typedef struct packed {
    logic [1:0] len_code;
    logic [1:0] par_code;
    logic       stop_long;
  } frame_fmt_t;

  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;

  function automatic logic parity_on(input logic [1:0] code);
    return (code == PAR_EVEN) || (code == PAR_ODD);
  endfunction

  function automatic logic parity_of(input logic [CHAR_W-1:0] d,
                                     input logic [1:0] len,
                                     input logic [1:0] code);
    logic [CHAR_W-1:0] mask;
    logic x;
    mask = {CHAR_W{1'b1}} >> (2'd3 - len);
    x = ^(d & mask);
    return (code == PAR_ODD) ? ~x : x;
  endfunction

endpackage

// File: rtl/tx_baud_gen.sv
module tx_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] count_q;
  logic [DIV_W-1:0] reload;

  // zero wraps to all ones, giving 2**DIV_W cycles per tick
  assign reload = DIV_W'(divisor - 1'b1);
  assign tick   = en && (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (en) begin
      if (count_q == '0) count_q <= reload;
      else               count_q <= count_q - 1'b1;
    end
  end

  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor != DIV_W'(1)) |=> !tick);

endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);

  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready = !full_q;
  assign full     = full_q;
  assign data     = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (take) full_q <= 1'b0;
      if (in_valid && !full_q) begin
        full_q <= 1'b1;
        data_q <= in_data;
      end
    end
  end

  // R6
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && full_q) |=> in_ready);

endmodule

// File: rtl/tx_frame_engine.sv
module tx_frame_engine
  import serial_tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [CHAR_W-1:0] hold_data,
  input  frame_fmt_t        fmt,
  output logic              take,
  output logic              line,
  output logic              idle
);

  localparam int SUB_W = $clog2(2 * OVS);
  localparam logic [SUB_W-1:0] BIT_LAST    = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] STOP1_LAST  = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] STOP15_LAST = SUB_W'(OVS + OVS / 2 - 1);
  localparam logic [SUB_W-1:0] STOP2_LAST  = SUB_W'(2 * OVS - 1);

  tx_phase_e         phase_q;
  logic [SUB_W-1:0]  sub_q;
  logic [CHAR_W-1:0] shreg_q;
  logic [2:0]        bit_idx_q;
  frame_fmt_t        fmt_q;
  logic              par_q;

  logic [2:0]        last_idx;
  logic [SUB_W-1:0]  stop_last;
  logic              bit_end;
  logic              stop_end;

  assign last_idx = 3'd4 + {1'b0, fmt_q.len_code};

  always_comb begin
    if (!fmt_q.stop_long)             stop_last = STOP1_LAST;
    else if (fmt_q.len_code == 2'd0)  stop_last = STOP15_LAST;
    else                              stop_last = STOP2_LAST;
  end

  assign bit_end  = tick && (sub_q == BIT_LAST);
  assign stop_end = tick && (phase_q == TX_STOP) && (sub_q == stop_last);
  assign take     = hold_full && ((phase_q == TX_IDLE) || stop_end);
  assign idle     = (phase_q == TX_IDLE);

  always_comb begin
    unique case (phase_q)
      TX_START: line = 1'b0;
      TX_DATA:  line = shreg_q[0];
      TX_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= TX_IDLE;
      sub_q     <= '0;
      shreg_q   <= '0;
      bit_idx_q <= '0;
      fmt_q     <= '0;
      par_q     <= 1'b0;
    end else begin
      if (take) begin
        shreg_q   <= hold_data;
        fmt_q     <= fmt;
        par_q     <= parity_of(hold_data, fmt.len_code, fmt.par_code);
        bit_idx_q <= '0;
      end
      unique case (phase_q)
        TX_IDLE: begin
          if (hold_full) phase_q <= TX_WAIT;
        end
        TX_WAIT: begin
          if (tick) begin
            phase_q <= TX_START;
            sub_q   <= '0;
          end
        end
        TX_START: begin
          if (bit_end) begin
            phase_q <= TX_DATA;
            sub_q   <= '0;
          end else if (tick) begin
            sub_q <= sub_q + 1'b1;
          end
        end
        TX_DATA: begin
          if (bit_end) begin
            sub_q <= '0;
            if (bit_idx_q == last_idx) begin
              phase_q <= parity_on(fmt_q.par_code) ? TX_PAR : TX_STOP;
            end else begin
              bit_idx_q <= bit_idx_q + 1'b1;
              shreg_q   <= shreg_q >> 1;
            end
          end else if (tick) begin
            sub_q <= sub_q + 1'b1;
          end
        end
        TX_PAR: begin
          if (bit_end) begin
            phase_q <= TX_STOP;
            sub_q   <= '0;
          end else if (tick) begin
            sub_q <= sub_q + 1'b1;
          end
        end
        TX_STOP: begin
          if (stop_end) begin
            sub_q   <= '0;
            phase_q <= hold_full ? TX_START : TX_IDLE;
          end else if (tick) begin
            sub_q <= sub_q + 1'b1;
          end
        end
        default: phase_q <= TX_IDLE;
      endcase
    end
  end

  // R8
  wait_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == TX_WAIT && tick) |=> (phase_q == TX_START));

  // R4
  stop_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == TX_STOP) |-> (sub_q <= stop_last));

  // R11
  fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q inside {TX_START, TX_DATA, TX_PAR}) |=> $stable(fmt_q));

endmodule

// File: rtl/tx_pin_drive.sv
module tx_pin_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic force_break,
  input  logic loopback,
  output logic txd,
  output logic loop_txd
);

  logic txd_q;
  logic loop_q;
  logic past_ok;

  assign txd      = txd_q;
  assign loop_txd = loop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q   <= 1'b1;
      loop_q  <= 1'b1;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (force_break)   txd_q <= 1'b0;
      else if (loopback) txd_q <= 1'b1;
      else               txd_q <= line;
      loop_q <= loopback ? line : 1'b1;
    end
  end

  // R10
  break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(force_break)) |-> !txd);

  // R9
  loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(loopback && !force_break)) |-> txd);

endmodule

// File: rtl/serial_tx_channel.sv
module serial_tx_channel
  import serial_tx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [1:0]        data_len,
  input  logic [1:0]        par_mode,
  input  logic              stop_long,
  input  logic              force_break,
  input  logic              loopback,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  output logic              hold_empty,
  output logic              tx_empty,
  output logic              txd,
  output logic              loop_txd
);

  logic              tick;
  logic              take;
  logic              hold_full;
  logic [CHAR_W-1:0] hold_data;
  logic              line;
  logic              idle;
  frame_fmt_t        fmt;

  assign fmt.len_code  = data_len;
  assign fmt.par_code  = par_mode;
  assign fmt.stop_long = stop_long;

  tx_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (clk_en),
    .divisor (divisor),
    .tick    (tick)
  );

  tx_hold_reg #(.W(CHAR_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .take     (take),
    .full     (hold_full),
    .data     (hold_data)
  );

  tx_frame_engine #(.OVS(OVS)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .fmt       (fmt),
    .take      (take),
    .line      (line),
    .idle      (idle)
  );

  tx_pin_drive u_pin (
    .clk         (clk),
    .rst_n       (rst_n),
    .line        (line),
    .force_break (force_break),
    .loopback    (loopback),
    .txd         (txd),
    .loop_txd    (loop_txd)
  );

  assign hold_empty = !hold_full;
  assign tx_empty   = !hold_full && idle;

endmodule

// File: tb/tb_serial_tx_channel.sv
`timescale 1ns/1ps
module tb_serial_tx_channel;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clk_en;
  logic [15:0] divisor;
  logic [1:0]  data_len;
  logic [1:0]  par_mode;
  logic        stop_long;
  logic        force_break;
  logic        loopback;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_ready;
  logic        hold_empty;
  logic        tx_empty;
  logic        txd;
  logic        loop_txd;

  int checks = 0;
  int failures = 0;
  int ncyc = 0;
  bit timed_out = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) ncyc <= ncyc + 1;

  serial_tx_channel dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .divisor(divisor),
    .data_len(data_len), .par_mode(par_mode), .stop_long(stop_long),
    .force_break(force_break), .loopback(loopback),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .hold_empty(hold_empty), .tx_empty(tx_empty), .txd(txd), .loop_txd(loop_txd)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic pin_val(input bit sel);
    return sel ? loop_txd : txd;
  endfunction

  function automatic int frame_ticks(input int len, input int par, input bit sl);
    int nd;
    int st;
    nd = 5 + len;
    st = !sl ? 16 : ((len == 0) ? 24 : 32);
    return 16 * (1 + nd + ((par == 1 || par == 2) ? 1 : 0)) + st;
  endfunction

  task automatic wait_until(input int t);
    while (ncyc < t) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    chk(in_ready == 1'b0, "R6", "ready low after accept", in_ready, 0);
    in_valid = 1'b0;
  endtask

  task automatic wait_fall(input bit sel, output int tf);
    @(negedge clk);
    while (pin_val(sel) != 1'b0) @(negedge clk);
    tf = ncyc;
  endtask

  // expected bits: start, data LSB first, optional parity, first stop bit
  task automatic check_frame(input logic [7:0] b, input int len, input int par,
                             input bit sel, input int div, output int tf);
    logic [11:0] bits;
    int nb;
    int nd;
    int bad;
    int lbad;
    logic x;
    nd = 5 + len;
    bits = '0;
    nb = 0;
    bits[nb] = 1'b0; nb++;
    x = 1'b0;
    for (int i = 0; i < nd; i++) begin
      bits[nb] = b[i]; nb++;
      x ^= b[i];
    end
    if (par == 1) begin bits[nb] = x;  nb++; end
    if (par == 2) begin bits[nb] = ~x; nb++; end
    bits[nb] = 1'b1; nb++;
    bad = 0;
    lbad = 0;
    wait_fall(sel, tf);
    for (int i = 0; i < nb; i++) begin
      wait_until(tf + (16 * i + 8) * div);
      if (pin_val(sel) != bits[i]) bad++;
      if (pin_val(!sel) != 1'b1) lbad++;
    end
    chk(bad == 0, "R2,R3", $sformatf("frame bit mismatches len=%0d par=%0d", len, par), bad, 0);
    chk(lbad == 0, "R9", "unused serial output not high", lbad, 0);
  endtask

  task automatic set_fmt(input int len, input int par, input bit sl, input int div);
    @(negedge clk);
    data_len  = 2'(len);
    par_mode  = 2'(par);
    stop_long = sl;
    divisor   = 16'(div);
  endtask

  task automatic run_pair(input int len, input int par, input bit sl, input int div,
                          input logic [7:0] a, input logic [7:0] b);
    int fa;
    int fb;
    int n;
    n = frame_ticks(len, par, sl);
    set_fmt(len, par, sl, div);
    fork
      begin
        push(a);
        push(b);
      end
      begin
        check_frame(a, len, par, 1'b0, div, fa);
        wait_until(fa + n * div - 2);
        chk(hold_empty == 1'b0, "R6", "holding still full before copy", hold_empty, 0);
        chk(tx_empty == 1'b0, "R7", "tx_empty low with queued char", tx_empty, 0);
        @(negedge clk);
        chk(hold_empty == 1'b1, "R6", "holding empty after copy", hold_empty, 1);
        check_frame(b, len, par, 1'b0, div, fb);
        chk(fb - fa == n * div, "R4,R8", $sformatf("frame spacing len=%0d sl=%0d", len, sl),
            fb - fa, n * div);
        wait_until(fb + n * div - 2);
        chk(tx_empty == 1'b0, "R7", "tx_empty low before stop end", tx_empty, 0);
        @(negedge clk);
        chk(tx_empty == 1'b1, "R7", "tx_empty high at stop end", tx_empty, 1);
      end
    join
  endtask

  task automatic check_reset_state();
    chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
    chk(loop_txd == 1'b1, "R1", "loop_txd after reset", loop_txd, 1);
    chk(hold_empty == 1'b1 && in_ready == 1'b1, "R1", "holding empty after reset",
        hold_empty, 1);
    chk(tx_empty == 1'b1, "R1", "tx_empty after reset", tx_empty, 1);
  endtask

  task automatic run_all();
    int fa;
    int t0;
    int n;
    int idx;
    logic [7:0] a;
    rst_n = 1'b0; clk_en = 1'b1; divisor = 16'd2; data_len = 2'd3; par_mode = 2'd0;
    stop_long = 1'b0; force_break = 1'b0; loopback = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    // full sweep of frame formats, two characters back to back
    idx = 0;
    for (int len = 0; len < 4; len++)
      for (int par = 0; par < 4; par++)
        for (int sl = 0; sl < 2; sl++) begin
          if (par == 3 && sl == 1) continue;
          a = 8'(8'h3C + idx * 29);
          run_pair(len, par, sl[0], 2, a, ~a ^ 8'h81);
          idx++;
        end

    // other divisor values (R5)
    run_pair(3, 1, 1'b0, 3, 8'hA7, 8'h1E);
    run_pair(1, 2, 1'b1, 1, 8'h2D, 8'h33);

    // R11: format change mid-frame is ignored
    set_fmt(3, 0, 1'b0, 2);
    n = frame_ticks(3, 0, 1'b0);
    fork
      push(8'hC9);
      check_frame(8'hC9, 3, 0, 1'b0, 2, fa);
      begin
        @(negedge clk);
        while (txd != 1'b0) @(negedge clk);
        repeat (20) @(negedge clk);
        data_len = 2'd0; par_mode = 2'd1; stop_long = 1'b1;
      end
    join
    wait_until(fa + n * 2 - 2);
    chk(tx_empty == 1'b0, "R11", "frame length kept after format change", tx_empty, 0);
    @(negedge clk);
    chk(tx_empty == 1'b1, "R11", "frame ends at captured length", tx_empty, 1);

    // R9: loopback
    set_fmt(3, 1, 1'b0, 2);
    loopback = 1'b1;
    n = frame_ticks(3, 1, 1'b0);
    fork
      push(8'h6B);
      check_frame(8'h6B, 3, 1, 1'b1, 2, fa);
    join
    wait_until(fa + n * 2);
    chk(tx_empty == 1'b1 && txd == 1'b1, "R9", "loopback frame done, pin high",
        txd, 1);
    loopback = 1'b0;

    // R10: break with tick enable off and with loopback on
    @(negedge clk);
    clk_en = 1'b0;
    force_break = 1'b1;
    loopback = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0, "R10", "break drives pin low", txd, 0);
    repeat (5) @(negedge clk);
    chk(txd == 1'b0, "R10", "break held low", txd, 0);
    force_break = 1'b0;
    loopback = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R10", "pin released after break", txd, 1);
    clk_en = 1'b1;

    // R5: divisor zero means 65536 cycles per tick
    set_fmt(3, 0, 1'b0, 1);
    repeat (4) @(negedge clk);
    divisor = 16'd0;
    t0 = ncyc;
    push(8'h55);
    wait_fall(1'b0, fa);
    chk((fa - t0) >= 65500 && (fa - t0) <= 65560, "R5", "cycles to start bit with divisor 0",
        fa - t0, 65536);

    // reset mid-frame returns to the idle state
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    divisor = 16'd2;
    @(negedge clk);
    check_reset_state();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (195000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", ncyc, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule